// File: doc/BRIEF.md
# Segment base-limit translation unit

This block turns a logical address into a physical address using a small table of segment descriptors held on chip. A logical address is a segment selector and an offset inside that segment. Each descriptor holds a base address, a limit (the segment size), three rights bits and a present flag. The lookup is purely combinational: the selector picks a descriptor, the offset is compared with that descriptor's limit, and the access kind is compared with its rights. Only then is the base added to the offset. If any check fails, the block returns a fault code and drives a zero address.

Descriptors are loaded through a write port that looks like a register write. A write is committed at the rising clock edge. A lookup made in the same cycle as a write still sees the previous contents of that entry. On reset, every descriptor becomes not present, so every lookup faults until software loads the table.

Typical use puts the block between an address generator and the memory port. The fault code feeds an exception path, and the physical address is used only when the code is zero.

Top module: `seg_xlat_unit`

## Requirements
- R1: After reset, and before any descriptor write, every lookup returns fault code 1 (absent) and physical address 0, whatever the selector, offset or access kind.
- R2: When no fault is raised, the physical address equals the descriptor base plus the zero-extended offset, taken modulo 2^PA_W (a sum past the top of the physical space wraps around).
- R3: An offset greater than or equal to the descriptor limit gives fault code 2 (bound). An offset equal to limit-1 passes, and a limit of 0 makes every offset fault.
- R4: The rights field has bit 0 = read allowed, bit 1 = write allowed and bit 2 = execute allowed. The access kind is coded 0 = read, 1 = write, 2 = execute and 3 = invalid. An access whose kind is not allowed by the rights, or whose kind is 3, gives fault code 3 (rights). As a result, a segment with rights 3'b101 (code style) rejects writes, and a segment with rights 3'b011 (data style) rejects execution.
- R5: Faults are checked in a fixed priority order: absent (1) first, then bound (2), then rights (3). Fault code 0 means the access is valid.
- R6: Whenever the fault code is not 0, the physical address output is 0.
- R7: A descriptor write takes effect at the rising clock edge. A lookup of the same selector in the cycle of the write returns the result for the old contents. Writing a descriptor with the present flag clear makes that selector fault with code 1 from the next cycle on.
- R8: A descriptor write changes only the entry named by its selector. Lookups of every other selector return the same results as before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; descriptor writes commit on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; marks all descriptors not present |
| wr_en | input | 1 | Descriptor write strobe |
| wr_sel | input | SEL_W | Index of the descriptor being written |
| wr_base | input | PA_W | Base physical address to store |
| wr_limit | input | OFS_W+1 | Segment size to store; offsets must be below it |
| wr_rights | input | 3 | Rights to store: bit0 read, bit1 write, bit2 execute |
| wr_present | input | 1 | Present flag to store |
| lk_sel | input | SEL_W | Segment selector of the lookup |
| lk_offset | input | OFS_W | Offset inside the segment |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 invalid |
| lk_paddr | output | PA_W | Translated physical address, 0 on fault |
| lk_fault | output | 2 | 0 none, 1 absent, 2 bound, 3 rights |

## Verification
The bench probes the limit edge at limit-1 and at exactly the limit. A design that uses a less-or-equal comparison lets one byte past the end of the segment through. It also checks a zero limit and an address sum that wraps, which catches a design that treats a zero size as the full range or mishandles the carry. Priority is tested with accesses that break several rules at once, so a design with the checks in the wrong order returns the wrong code. A lookup made in the same cycle as a write to that entry must return the old result, which exposes a bypass path from the write port to the read port. Rewriting one entry, including clearing its present flag, must leave every other entry unchanged, which exposes a bad index decode.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_BOUND  = 2'd2,
        FLT_RIGHTS = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_BAD   = 2'd3
    } acc_e;

    localparam int RIGHTS_W = 3;
    localparam int RGT_RD   = 0;
    localparam int RGT_WR   = 1;
    localparam int RGT_EX   = 2;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlat_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int PA_W  = 20,
    parameter int LIM_W = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [PA_W-1:0]     wr_base,
    input  logic [LIM_W-1:0]    wr_limit,
    input  logic [RIGHTS_W-1:0] wr_rights,
    input  logic                wr_present,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [PA_W-1:0]     rd_base,
    output logic [LIM_W-1:0]    rd_limit,
    output logic [RIGHTS_W-1:0] rd_rights,
    output logic                rd_present
);
    localparam int DEPTH = 1 << SEL_W;

    logic [PA_W-1:0]     base_q   [DEPTH];
    logic [LIM_W-1:0]    limit_q  [DEPTH];
    logic [RIGHTS_W-1:0] rights_q [DEPTH];
    logic [DEPTH-1:0]    present_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                base_q[i]   <= '0;
                limit_q[i]  <= '0;
                rights_q[i] <= '0;
            end
            present_q <= '0;
        end else if (wr_en) begin
            base_q[wr_sel]    <= wr_base;
            limit_q[wr_sel]   <= wr_limit;
            rights_q[wr_sel]  <= wr_rights;
            present_q[wr_sel] <= wr_present;
        end
    end

    always_comb begin
        rd_base    = base_q[rd_sel];
        rd_limit   = limit_q[rd_sel];
        rd_rights  = rights_q[rd_sel];
        rd_present = present_q[rd_sel];
    end

endmodule

// File: rtl/seg_fault_eval.sv
module seg_fault_eval
    import seg_xlat_pkg::*;
#(
    parameter int OFS_W = 12,
    parameter int LIM_W = 13
) (
    input  logic                d_present,
    input  logic [LIM_W-1:0]    d_limit,
    input  logic [RIGHTS_W-1:0] d_rights,
    input  logic [OFS_W-1:0]    offset,
    input  acc_e                kind,
    output fault_e              fault
);
    logic [LIM_W-1:0] ofs_ext;
    logic             kind_ok;

    assign ofs_ext = LIM_W'(offset);

    always_comb begin
        unique case (kind)
            ACC_READ:  kind_ok = d_rights[RGT_RD];
            ACC_WRITE: kind_ok = d_rights[RGT_WR];
            ACC_EXEC:  kind_ok = d_rights[RGT_EX];
            default:   kind_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (!d_present)
            fault = FLT_ABSENT;
        else if (ofs_ext >= d_limit)
            fault = FLT_BOUND;
        else if (!kind_ok)
            fault = FLT_RIGHTS;
        else
            fault = FLT_NONE;
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_xlat_pkg::*;
#(
    parameter int OFS_W = 12,
    parameter int PA_W  = 20
) (
    input  logic [PA_W-1:0]  base,
    input  logic [OFS_W-1:0] offset,
    input  fault_e           fault,
    output logic [PA_W-1:0]  paddr
);
    logic [PA_W-1:0] sum;

    assign sum   = base + PA_W'(offset);
    assign paddr = (fault == FLT_NONE) ? sum : '0;

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
    import seg_xlat_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int OFS_W = 12,
    parameter int PA_W  = 20,
    localparam int LIM_W = OFS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [LIM_W-1:0] wr_limit,
    input  logic [2:0]       wr_rights,
    input  logic             wr_present,
    input  logic [SEL_W-1:0] lk_sel,
    input  logic [OFS_W-1:0] lk_offset,
    input  logic [1:0]       lk_kind,
    output logic [PA_W-1:0]  lk_paddr,
    output logic [1:0]       lk_fault
);
    logic [PA_W-1:0]     d_base;
    logic [LIM_W-1:0]    d_limit;
    logic [RIGHTS_W-1:0] d_rights;
    logic                d_present;
    fault_e              fault;

    seg_desc_table #(.SEL_W(SEL_W), .PA_W(PA_W), .LIM_W(LIM_W)) table_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_base    (wr_base),
        .wr_limit   (wr_limit),
        .wr_rights  (wr_rights),
        .wr_present (wr_present),
        .rd_sel     (lk_sel),
        .rd_base    (d_base),
        .rd_limit   (d_limit),
        .rd_rights  (d_rights),
        .rd_present (d_present)
    );

    seg_fault_eval #(.OFS_W(OFS_W), .LIM_W(LIM_W)) eval_i (
        .d_present (d_present),
        .d_limit   (d_limit),
        .d_rights  (d_rights),
        .offset    (lk_offset),
        .kind      (acc_e'(lk_kind)),
        .fault     (fault)
    );

    seg_addr_gen #(.OFS_W(OFS_W), .PA_W(PA_W)) addr_i (
        .base   (d_base),
        .offset (lk_offset),
        .fault  (fault),
        .paddr  (lk_paddr)
    );

    assign lk_fault = fault;

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
    parameter int SEL_W = 3,
    parameter int OFS_W = 12,
    parameter int PA_W  = 20,
    localparam int LIM_W = OFS_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [PA_W-1:0]  wr_base,
    input logic [LIM_W-1:0] wr_limit,
    input logic [2:0]       wr_rights,
    input logic             wr_present,
    input logic [SEL_W-1:0] lk_sel,
    input logic [OFS_W-1:0] lk_offset,
    input logic [1:0]       lk_kind,
    input logic [PA_W-1:0]  lk_paddr,
    input logic [1:0]       lk_fault
);
    logic past_ok;
    logic any_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            any_wr  <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (wr_en) any_wr <= 1'b1;
        end
    end

    assert_empty_table_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |-> (lk_fault == 2'd1 && lk_paddr == '0));

    assert_fault_zero_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault != 2'd0) |-> (lk_paddr == '0));

    assert_absent_after_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en && !wr_present) && lk_sel == $past(wr_sel))
        |-> (lk_fault == 2'd1));

    assert_bound_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en && wr_present) && lk_sel == $past(wr_sel)
         && LIM_W'(lk_offset) >= $past(wr_limit))
        |-> (lk_fault == 2'd2));

    assert_sum_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en && wr_present && wr_rights == 3'b111)
         && lk_sel == $past(wr_sel) && LIM_W'(lk_offset) < $past(wr_limit)
         && lk_kind != 2'd3)
        |-> (lk_fault == 2'd0
             && lk_paddr == PA_W'($past(wr_base) + PA_W'(lk_offset))));

endmodule

bind seg_xlat_unit seg_xlat_chk #(.SEL_W(SEL_W), .OFS_W(OFS_W), .PA_W(PA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_base    (wr_base),
    .wr_limit   (wr_limit),
    .wr_rights  (wr_rights),
    .wr_present (wr_present),
    .lk_sel     (lk_sel),
    .lk_offset  (lk_offset),
    .lk_kind    (lk_kind),
    .lk_paddr   (lk_paddr),
    .lk_fault   (lk_fault)
);

// File: tb/seg_xlat_unit_tb_top.sv
`timescale 1ns/1ps
module seg_xlat_unit_tb_top;
    localparam int SEL_W = 3;
    localparam int OFS_W = 12;
    localparam int PA_W  = 20;
    localparam int LIM_W = OFS_W + 1;
    localparam int DEPTH = 1 << SEL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [SEL_W-1:0] wr_sel = '0;
    logic [PA_W-1:0]  wr_base = '0;
    logic [LIM_W-1:0] wr_limit = '0;
    logic [2:0]       wr_rights = '0;
    logic             wr_present = 1'b0;
    logic [SEL_W-1:0] lk_sel = '0;
    logic [OFS_W-1:0] lk_offset = '0;
    logic [1:0]       lk_kind = '0;
    logic [PA_W-1:0]  lk_paddr;
    logic [1:0]       lk_fault;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [PA_W-1:0]  m_base   [DEPTH];
    logic [LIM_W-1:0] m_limit  [DEPTH];
    logic [2:0]       m_rights [DEPTH];
    logic             m_pres   [DEPTH];

    always #4 clk = ~clk;

    seg_xlat_unit #(.SEL_W(SEL_W), .OFS_W(OFS_W), .PA_W(PA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_base(wr_base), .wr_limit(wr_limit), .wr_rights(wr_rights),
        .wr_present(wr_present), .lk_sel(lk_sel), .lk_offset(lk_offset),
        .lk_kind(lk_kind), .lk_paddr(lk_paddr), .lk_fault(lk_fault)
    );

    function automatic void model_expect(input int s, input logic [OFS_W-1:0] o,
                                         input logic [1:0] k,
                                         output logic [1:0] ef, output logic [PA_W-1:0] ea);
        logic ok;
        ok = (k == 2'd0) ? m_rights[s][0] :
             (k == 2'd1) ? m_rights[s][1] :
             (k == 2'd2) ? m_rights[s][2] : 1'b0;
        if (!m_pres[s])                      ef = 2'd1;
        else if (LIM_W'(o) >= m_limit[s])    ef = 2'd2;
        else if (!ok)                        ef = 2'd3;
        else                                 ef = 2'd0;
        ea = (ef == 2'd0) ? PA_W'(m_base[s] + PA_W'(o)) : '0;
    endfunction

    task automatic compare(input string tag, input logic [1:0] ef, input logic [PA_W-1:0] ea);
        n_vec++;
        if (lk_fault !== ef || lk_paddr !== ea) begin
            n_bad++;
            $display("FAIL %s: sel=%0d ofs=%h kind=%0d got fault=%0d paddr=%h expected fault=%0d paddr=%h",
                     tag, lk_sel, lk_offset, lk_kind, lk_fault, lk_paddr, ef, ea);
        end
    endtask

    task automatic load(input int s, input logic [PA_W-1:0] b, input logic [LIM_W-1:0] l,
                        input logic [2:0] r, input logic p);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = SEL_W'(s); wr_base = b; wr_limit = l;
        wr_rights = r; wr_present = p;
        @(negedge clk);
        wr_en = 1'b0;
        m_base[s] = b; m_limit[s] = l; m_rights[s] = r; m_pres[s] = p;
    endtask

    task automatic probe(input string tag, input int s, input logic [OFS_W-1:0] o,
                         input logic [1:0] k, input logic [1:0] ef, input logic [PA_W-1:0] ea);
        @(negedge clk);
        lk_sel = SEL_W'(s); lk_offset = o; lk_kind = k;
        #1 compare(tag, ef, ea);
    endtask

    task automatic probe_model(input string tag, input int s, input logic [OFS_W-1:0] o,
                               input logic [1:0] k);
        logic [1:0] ef; logic [PA_W-1:0] ea;
        model_expect(s, o, k, ef, ea);
        probe(tag, s, o, k, ef, ea);
    endtask

    task automatic t_reset_state;
        for (int s = 0; s < DEPTH; s++)
            for (int k = 0; k < 4; k++)
                probe("R1 reset absent", s, OFS_W'(s * 37), 2'(k), 2'd1, '0);
    endtask

    task automatic t_code_segment;
        load(1, 20'h10000, 13'h100, 3'b101, 1'b1);
        probe("R2 code exec", 1, 12'h020, 2'd2, 2'd0, 20'h10020);
        probe("R2 code read", 1, 12'h0FF, 2'd0, 2'd0, 20'h100FF);
        probe("R4 code write rejected", 1, 12'h020, 2'd1, 2'd3, '0);
        probe("R4 kind 3 rejected", 1, 12'h000, 2'd3, 2'd3, '0);
    endtask

    task automatic t_data_segment;
        load(2, 20'h50000, 13'h200, 3'b011, 1'b1);
        probe("R4 data exec rejected", 2, 12'h010, 2'd2, 2'd3, '0);
        probe("R3 limit-1 passes", 2, 12'h1FF, 2'd1, 2'd0, 20'h501FF);
        probe("R3 offset at limit", 2, 12'h200, 2'd0, 2'd2, '0);
        load(3, 20'h60000, 13'h000, 3'b111, 1'b1);
        probe("R3 zero limit", 3, 12'h000, 2'd0, 2'd2, '0);
    endtask

    task automatic t_priority;
        probe("R5 bound over rights", 2, 12'h300, 2'd2, 2'd2, '0);
        probe("R5 absent over all", 4, 12'hFFF, 2'd3, 2'd1, '0);
        load(4, 20'h00000, 13'h010, 3'b000, 1'b0);
        probe("R5 absent over bound", 4, 12'h800, 2'd1, 2'd1, '0);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd5; wr_base = 20'h70000; wr_limit = 13'h080;
        wr_rights = 3'b111; wr_present = 1'b1;
        lk_sel = 3'd5; lk_offset = 12'h040; lk_kind = 2'd0;
        #1 compare("R7 same-cycle old contents", 2'd1, '0);
        @(negedge clk);
        wr_en = 1'b0;
        m_base[5] = 20'h70000; m_limit[5] = 13'h080; m_rights[5] = 3'b111; m_pres[5] = 1'b1;
        #1 compare("R7 next-cycle new contents", 2'd0, 20'h70040);
        load(5, 20'h70000, 13'h080, 3'b111, 1'b0);
        probe("R7 cleared present", 5, 12'h040, 2'd0, 2'd1, '0);
    endtask

    task automatic t_isolation;
        probe_model("R8 seg1 intact", 1, 12'h0AB, 2'd2);
        probe_model("R8 seg2 intact", 2, 12'h123, 2'd1);
        probe_model("R8 seg3 intact", 3, 12'h001, 2'd0);
        probe("R8 untouched seg absent", 7, 12'h001, 2'd0, 2'd1, '0);
    endtask

    task automatic t_wrap;
        load(6, 20'hFFFF0, 13'h1000, 3'b001, 1'b1);
        probe("R2 wraparound", 6, 12'h020, 2'd0, 2'd0, 20'h00010);
        probe("R2 top of range", 6, 12'hFFF, 2'd0, 2'd0, 20'h00FEF);
        probe("R6 rights fault zero addr", 6, 12'h020, 2'd1, 2'd3, '0);
    endtask

    initial begin
        for (int s = 0; s < DEPTH; s++) begin
            m_base[s] = '0; m_limit[s] = '0; m_rights[s] = '0; m_pres[s] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state;
        t_code_segment;
        t_data_segment;
        t_priority;
        t_same_cycle;
        t_isolation;
        t_wrap;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule